// File: doc/BRIEF.md
# Four-Mode Text Video Timing Selector

This block paces a character-cell text display that runs in one of four geometries. Two mode inputs act independently: a width bit chooses between the narrow geometry (64 columns by 16 rows) and the wide geometry (80 columns by 24 rows), and a doubling bit halves the column count so that each glyph spans two cell periods. The width bit also picks which of two dot-reference ticks drives the character pacing. The low-rate reference nominally runs at 10.1376 MHz and the high-rate reference at 12.672 MHz. Both arrive as single-cycle tick pulses already synchronised to the block clock.

A 4-bit synchronous dot counter divides the selected reference into character periods. In doubled mode every second period produces a character-clock enable. Column and row counters advance on that enable and run through a blanking interval after the active area. Horizontal and vertical sync windows sit at parameterised offsets into blanking. The mode inputs are captured only at the end of a frame, so a frame never mixes two geometries.

Top module: `vid_mode_timer`

## Requirements
- R1: While reset is held, and after it is released until the first character enable, `col` and `row` are 0, `char_en` is low, and the geometry is 64 columns by 16 rows.
- R2: The latched mode {`dbl_width`,`wide_mode`} selects the geometry reported on `active_cols`/`active_rows`: 00 gives 64x16, 10 gives 32x16, 01 gives 80x24 and 11 gives 40x24.
- R3: With `wide_mode` latched at 0 only `ref_lo_tick` paces characters, and with it latched at 1 only `ref_hi_tick` does. Ticks on the other reference have no effect on `char_en`, `col` or `row`.
- R4: In single width, `char_en` is high in the cycle of every DOTS_PER_CHAR-th selected tick, and in no other cycle.
- R5: In doubled width, `char_en` is high once for every 2*DOTS_PER_CHAR selected ticks.
- R6: `col` rises by one in the cycle after `char_en`. It returns to 0 after reaching `active_cols`+HBLANK-1.
- R7: `row` rises by one on each column wrap. It returns to 0 after reaching `active_rows`+VBLANK-1.
- R8: The mode inputs are captured only in the frame-end cycle, which is `char_en` with `col` and `row` both at their last values. The new geometry shows on the next cycle. Changes to the mode inputs at any other time are ignored.
- R9: `hsync` is high exactly when `col` lies in [`active_cols`+HSYNC_OFS, `active_cols`+HSYNC_OFS+HSYNC_LEN). `vsync` is high exactly when `row` lies in [`active_rows`+VSYNC_OFS, `active_rows`+VSYNC_OFS+VSYNC_LEN).
- R10: In any cycle without `char_en`, `col` and `row` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_lo_tick | input | 1 | One-cycle pulse per dot of the 10.1376 MHz reference |
| ref_hi_tick | input | 1 | One-cycle pulse per dot of the 12.672 MHz reference |
| dbl_width | input | 1 | Doubling bit: 1 halves columns and doubles glyph width |
| wide_mode | input | 1 | Width bit: 0 selects the 64-column family, 1 the 80-column family |
| char_en | output | 1 | Character clock enable |
| col | output | COL_W (7) | Column position, including blanking |
| row | output | ROW_W (5) | Row position, including blanking |
| active_cols | output | COL_W (7) | Visible columns of the latched mode |
| active_rows | output | ROW_W (5) | Visible rows of the latched mode |
| hsync | output | 1 | Horizontal sync window |
| vsync | output | 1 | Vertical sync window |

## Verification
`char_en` is combinational from the selected tick and the dot counter, so it is due in the same cycle as the tick that completes a character period. `col`, `row` and the latched geometry change one clock edge after that cycle. The sync outputs follow `col` and `row` combinationally. Tick pulses are driven just after the rising edge, and every output is sampled on the falling edge. At each sample the bench compares `char_en`, `hsync` and `vsync` with values computed from the counters the bench itself keeps. It advances its expected column, row and mode only after sampling a `char_en`, so each check against a registered output falls on the edge after the cause.

// File: rtl/vmt_pkg.sv
package vmt_pkg;

  typedef struct packed {
    logic dbl;   // doubled glyph width, columns halved
    logic wide;  // 80-column family on the high-rate reference
  } vmt_mode_t;

  localparam vmt_mode_t VMT_MODE_RESET = '{dbl: 1'b0, wide: 1'b0};

endpackage

// File: rtl/vmt_rst_sync.sv
module vmt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end

endmodule

// File: rtl/vmt_mode_reg.sv
module vmt_mode_reg
  import vmt_pkg::*;
#(
  parameter int COLS_NARROW = 64,
  parameter int COLS_WIDE   = 80,
  parameter int ROWS_NARROW = 16,
  parameter int ROWS_WIDE   = 24,
  parameter int COL_W       = 7,
  parameter int ROW_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbl_in,
  input  logic             wide_in,
  input  logic             load,
  output vmt_mode_t        mode_q,
  output logic [COL_W-1:0] active_cols,
  output logic [ROW_W-1:0] active_rows
);

  localparam logic [COL_W-1:0] C_NARROW      = COL_W'(COLS_NARROW);
  localparam logic [COL_W-1:0] C_WIDE        = COL_W'(COLS_WIDE);
  localparam logic [COL_W-1:0] C_NARROW_HALF = COL_W'(COLS_NARROW / 2);
  localparam logic [COL_W-1:0] C_WIDE_HALF   = COL_W'(COLS_WIDE / 2);
  localparam logic [ROW_W-1:0] R_NARROW      = ROW_W'(ROWS_NARROW);
  localparam logic [ROW_W-1:0] R_WIDE        = ROW_W'(ROWS_WIDE);

  vmt_mode_t mode_d;

  always_comb begin
    mode_d = mode_q;
    if (load) begin
      mode_d.dbl  = dbl_in;
      mode_d.wide = wide_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= VMT_MODE_RESET;
    else        mode_q <= mode_d;
  end

  always_comb begin
    unique case ({mode_q.dbl, mode_q.wide})
      2'b00:   active_cols = C_NARROW;
      2'b10:   active_cols = C_NARROW_HALF;
      2'b01:   active_cols = C_WIDE;
      default: active_cols = C_WIDE_HALF;
    endcase
    active_rows = mode_q.wide ? R_WIDE : R_NARROW;
  end

endmodule

// File: rtl/vmt_char_pacer.sv
module vmt_char_pacer #(
  parameter int DOT_W         = 4,
  parameter int DOTS_PER_CHAR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dot_tick,
  input  logic dbl,
  input  logic frame_end,
  output logic char_en
);

  localparam logic [DOT_W-1:0] DOT_LAST = DOT_W'(DOTS_PER_CHAR - 1);

  logic [DOT_W-1:0] dot_q, dot_d;
  logic             phase_q, phase_d;
  logic             period_done;

  always_comb begin
    period_done = dot_tick && (dot_q == DOT_LAST);
    dot_d       = dot_q;
    if (dot_tick) dot_d = period_done ? '0 : dot_q + 1'b1;
    phase_d = phase_q;
    if (frame_end)        phase_d = 1'b0;
    else if (period_done) phase_d = ~phase_q;
    char_en = period_done && (!dbl || phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      dot_q   <= dot_d;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/vmt_axis.sv
module vmt_axis #(
  parameter int W        = 7,
  parameter int BLANK    = 16,
  parameter int SYNC_OFS = 2,
  parameter int SYNC_LEN = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] active,
  output logic [W-1:0] pos,
  output logic         last,
  output logic         sync
);

  logic [W-1:0] pos_d;
  logic [W:0]   span_end, sync_lo, sync_hi;

  always_comb begin
    span_end = {1'b0, active} + (W+1)'(BLANK) - 1'b1;
    sync_lo  = {1'b0, active} + (W+1)'(SYNC_OFS);
    sync_hi  = sync_lo + (W+1)'(SYNC_LEN);
    last     = ({1'b0, pos} == span_end);
    sync     = ({1'b0, pos} >= sync_lo) && ({1'b0, pos} < sync_hi);
    pos_d    = pos;
    if (step) pos_d = last ? '0 : pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else        pos <= pos_d;
  end

endmodule

// File: rtl/vid_mode_timer.sv
module vid_mode_timer #(
  parameter int COLS_NARROW   = 64,
  parameter int COLS_WIDE     = 80,
  parameter int ROWS_NARROW   = 16,
  parameter int ROWS_WIDE     = 24,
  parameter int DOT_W         = 4,
  parameter int DOTS_PER_CHAR = 8,
  parameter int HBLANK        = 16,
  parameter int VBLANK        = 8,
  parameter int HSYNC_OFS     = 2,
  parameter int HSYNC_LEN     = 6,
  parameter int VSYNC_OFS     = 1,
  parameter int VSYNC_LEN     = 2,
  localparam int COL_W = $clog2(COLS_WIDE + HBLANK),
  localparam int ROW_W = $clog2(ROWS_WIDE + VBLANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_lo_tick,
  input  logic             ref_hi_tick,
  input  logic             dbl_width,
  input  logic             wide_mode,
  output logic             char_en,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] active_cols,
  output logic [ROW_W-1:0] active_rows,
  output logic             hsync,
  output logic             vsync
);

  import vmt_pkg::*;

  logic      rst_n_int;
  vmt_mode_t mode_q;
  logic      dot_tick, col_last, row_last, row_step, frame_end;

  vmt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  vmt_mode_reg #(
    .COLS_NARROW (COLS_NARROW),
    .COLS_WIDE   (COLS_WIDE),
    .ROWS_NARROW (ROWS_NARROW),
    .ROWS_WIDE   (ROWS_WIDE),
    .COL_W       (COL_W),
    .ROW_W       (ROW_W)
  ) u_mode (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .dbl_in      (dbl_width),
    .wide_in     (wide_mode),
    .load        (frame_end),
    .mode_q      (mode_q),
    .active_cols (active_cols),
    .active_rows (active_rows)
  );

  always_comb begin
    dot_tick  = mode_q.wide ? ref_hi_tick : ref_lo_tick;
    row_step  = char_en && col_last;
    frame_end = row_step && row_last;
  end

  vmt_char_pacer #(
    .DOT_W         (DOT_W),
    .DOTS_PER_CHAR (DOTS_PER_CHAR)
  ) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .dot_tick  (dot_tick),
    .dbl       (mode_q.dbl),
    .frame_end (frame_end),
    .char_en   (char_en)
  );

  vmt_axis #(
    .W        (COL_W),
    .BLANK    (HBLANK),
    .SYNC_OFS (HSYNC_OFS),
    .SYNC_LEN (HSYNC_LEN)
  ) u_h (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .step   (char_en),
    .active (active_cols),
    .pos    (col),
    .last   (col_last),
    .sync   (hsync)
  );

  vmt_axis #(
    .W        (ROW_W),
    .BLANK    (VBLANK),
    .SYNC_OFS (VSYNC_OFS),
    .SYNC_LEN (VSYNC_LEN)
  ) u_v (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .step   (row_step),
    .active (active_rows),
    .pos    (row),
    .last   (row_last),
    .sync   (vsync)
  );

endmodule

// File: rtl/vmt_checker.sv
module vmt_checker #(
  parameter int HBLANK    = 16,
  parameter int VBLANK    = 8,
  parameter int ROWS_WIDE = 24,
  parameter int COL_W     = 7,
  parameter int ROW_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_lo_tick,
  input logic             ref_hi_tick,
  input logic             char_en,
  input logic [COL_W-1:0] col,
  input logic [ROW_W-1:0] row,
  input logic [COL_W-1:0] active_cols,
  input logic [ROW_W-1:0] active_rows
);

  logic [COL_W-1:0] h_end;
  logic [ROW_W-1:0] v_end;
  logic             at_frame_end, wide_now;

  always_comb begin
    h_end        = COL_W'(int'(active_cols) + HBLANK - 1);
    v_end        = ROW_W'(int'(active_rows) + VBLANK - 1);
    at_frame_end = char_en && (col == h_end) && (row == v_end);
    wide_now     = (int'(active_rows) == ROWS_WIDE);
  end

  // R10: counters still without a character enable
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !char_en |=> $stable(col) && $stable(row));

  // R6: column steps by one inside a line
  p_col_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_en && col != h_end) |=> (col == $past(col) + 1'b1) && $stable(row));

  // R7: line wrap moves to the next row
  p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (char_en && col == h_end && row != v_end) |=> (col == '0) && (row == $past(row) + 1'b1));

  // R8: geometry frozen except at frame end
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !at_frame_end |=> $stable(active_cols) && $stable(active_rows));

  // R8: frame end restarts at the origin
  p_frame_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    at_frame_end |=> (col == '0) && (row == '0));

  // R3: enables only on the selected reference
  p_ref_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    char_en |-> (wide_now ? ref_hi_tick : ref_lo_tick));

  // R6, R7: positions never pass the end of blanking
  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (col <= h_end) && (row <= v_end));

endmodule

bind vid_mode_timer vmt_checker #(
  .HBLANK    (HBLANK),
  .VBLANK    (VBLANK),
  .ROWS_WIDE (ROWS_WIDE),
  .COL_W     (COL_W),
  .ROW_W     (ROW_W)
) u_vmt_checker (.*);

// File: tb/vid_mode_timer_bench.sv
module vid_mode_timer_bench;

  localparam int DPC  = 2;
  localparam int HB   = 4;
  localparam int VB   = 2;
  localparam int HSO  = 1;
  localparam int HSL  = 2;
  localparam int VSO  = 0;
  localparam int VSL  = 1;

  logic       clk, rst_n, ref_lo_tick, ref_hi_tick, dbl_width, wide_mode;
  logic       char_en, hsync, vsync;
  logic [6:0] col, active_cols;
  logic [4:0] row, active_rows;

  int  n_chk = 0, n_err = 0;
  bit  lo_en = 0, hi_en = 0, done = 0;
  bit  e_dbl = 0, e_wide = 0;

  vid_mode_timer #(
    .DOTS_PER_CHAR (DPC),
    .HBLANK        (HB),
    .VBLANK        (VB),
    .HSYNC_OFS     (HSO),
    .HSYNC_LEN     (HSL),
    .VSYNC_OFS     (VSO),
    .VSYNC_LEN     (VSL)
  ) u_vid_mode_timer (.*);

  initial clk = 0;
  always #4 clk = ~clk;

  // Reference dots: low-rate every 5 cycles, high-rate every 4 (ratio 1.25)
  initial begin
    int tk;
    tk = 0;
    ref_lo_tick = 0;
    ref_hi_tick = 0;
    forever begin
      @(posedge clk);
      #1;
      tk++;
      ref_lo_tick = lo_en && (tk % 5 == 0);
      ref_hi_tick = hi_en && (tk % 4 == 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int g_cols(bit d, bit w);
    int c;
    c = w ? 80 : 64;
    return d ? c / 2 : c;
  endfunction

  function automatic int g_rows(bit w);
    return w ? 24 : 16;
  endfunction

  task automatic t_reset();
    rst_n = 0; dbl_width = 0; wide_mode = 0;
    repeat (3) @(negedge clk);
    chk(col == 0, "R1 col in reset", int'(col), 0);
    chk(row == 0, "R1 row in reset", int'(row), 0);
    chk(char_en == 0, "R1 char_en in reset", int'(char_en), 0);
    chk(active_cols == 64, "R1 cols in reset", int'(active_cols), 64);
    chk(active_rows == 16, "R1 rows in reset", int'(active_rows), 16);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(col == 0 && row == 0, "R1 origin after release", int'(col) + int'(row), 0);
    lo_en = 1; hi_en = 1;
  endtask

  // Walk one full frame in the latched mode, requesting the next mode mid-frame.
  task automatic t_frame(input bit n_dbl, input bit n_wide);
    int ecol, erow, tcnt, ac, ar, need;
    bit changed, fin;
    ecol = 0; erow = 0; tcnt = 0; changed = 0; fin = 0;
    ac = g_cols(e_dbl, e_wide);
    ar = g_rows(e_wide);
    need = e_dbl ? 2 * DPC : DPC;
    @(negedge clk);
    chk(int'(active_cols) == ac, "R2 active_cols", int'(active_cols), ac);
    chk(int'(active_rows) == ar, "R2 active_rows", int'(active_rows), ar);
    chk(col == 0 && row == 0, "R8 frame starts at origin", int'(col) * 100 + int'(row), 0);
    while (!fin) begin
      if (e_wide ? ref_hi_tick : ref_lo_tick) tcnt++;
      chk(int'(col) == ecol, "R6/R10 col", int'(col), ecol);
      chk(int'(row) == erow, "R7/R10 row", int'(row), erow);
      chk(hsync == (ecol >= ac + HSO && ecol < ac + HSO + HSL), "R9 hsync", int'(hsync), ecol);
      chk(vsync == (erow >= ar + VSO && erow < ar + VSO + VSL), "R9 vsync", int'(vsync), erow);
      if (char_en) begin
        chk(tcnt == need, e_dbl ? "R5 ticks per doubled char" : "R4 ticks per char", tcnt, need);
        chk(int'(active_cols) == ac, "R8 cols stable mid-frame", int'(active_cols), ac);
        tcnt = 0;
        if (ecol == ac + HB - 1) begin
          ecol = 0;
          if (erow == ar + VB - 1) begin
            erow = 0;
            fin = 1;
          end else erow++;
        end else ecol++;
      end else begin
        chk(tcnt < need, "R3/R4 char_en missing", tcnt, need - 1);
      end
      if (!changed && erow == 1) begin
        dbl_width = n_dbl;
        wide_mode = n_wide;
        changed = 1;
      end
      if (!fin) @(negedge clk);
    end
    e_dbl = n_dbl;
    e_wide = n_wide;
  endtask

  // Unselected reference must not move anything (mode 00 latched).
  task automatic t_ignore_other();
    logic [6:0] c0;
    logic [4:0] r0;
    int seen;
    lo_en = 0;
    repeat (2) @(negedge clk);
    c0 = col; r0 = row; seen = 0;
    repeat (120) begin
      @(negedge clk);
      if (char_en) seen++;
    end
    chk(seen == 0, "R3 no char_en from other reference", seen, 0);
    chk(col == c0, "R3 col held", int'(col), int'(c0));
    chk(row == r0, "R3 row held", int'(row), int'(r0));
    lo_en = 1;
    seen = 0;
    repeat (60) begin
      @(negedge clk);
      if (char_en) seen++;
    end
    chk(seen > 0, "R3 selected reference resumes", seen, 1);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_frame(1'b1, 1'b0);  // 64x16, then request 32x16
    t_frame(1'b0, 1'b1);  // 32x16, then request 80x24
    t_frame(1'b1, 1'b1);  // 80x24, then request 40x24
    t_frame(1'b0, 1'b0);  // 40x24, then back to 64x16
    @(negedge clk);
    chk(int'(active_cols) == 64 && int'(active_rows) == 16, "R2 back to 64x16",
        int'(active_cols), 64);
    t_ignore_other();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule